// File: doc/BRIEF.md
# Census Hamming Disparity Selector

This block is the matching stage of a stereo depth pipeline built on census signatures. Two streams arrive in lockstep: one census signature per pixel from the reference camera and one from the target camera, with a flag that marks the first pixel of each image row. The block keeps the most recent target signatures of the current row. For every reference pixel it scores each candidate disparity by counting the differing bits between the reference signature and the target signature that many columns back, then reports the disparity with the fewest differing bits.

The cost for each candidate is the XOR of the two signatures followed by a bit count whose loop bound is the signature width. Candidates that would reach back past the start of the row are forced to the largest cost code. A registered binary tree then selects the minimum, one tree level per clock, so a new pixel can enter every cycle. A larger disparity means a nearer object. The winning cost is also reported, so a later stage can judge how good the match is.

Top module: `cen_disparity_sel`

## Requirements
- R1: The cost of disparity d for the pixel at row column u is the number of bit positions in which the reference signature at u differs from the target signature at column u-d of the same row.
- R2: Disparities 0 through NUM_DISP-1 (default 60) are searched; a match planted at the largest disparity, 59, is found.
- R3: The reported disparity `out_disp` is the candidate with the lowest cost.
- R4: When several candidates share the lowest cost, the smallest disparity is reported.
- R5: A candidate whose column u-d lies before the start of the row never wins, even if the earlier row held a perfect match. Such a candidate is excluded by giving it a cost of all ones, which is above any real cost.
- R6: A pixel with `row_start` high is column 0 of a new row; columns then count up by one per accepted pixel.
- R7: One pixel is accepted on every cycle with `in_valid` high, with no gaps required between pixels.
- R8: `out_valid` equals `in_valid` delayed by exactly 1 + ceil(log2(NUM_DISP)) clocks (7 by default), and the disparity and cost given with it belong to that pixel.
- R9: Cycles with `in_valid` low change neither the target history nor the column count, whatever the signature inputs carry.
- R10: While reset is asserted, and after it is released, `out_valid` is low until a pixel has passed through the pipeline.
- R11: `out_cost` is the cost of the reported disparity, which is never above SIG_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel pair is present this cycle |
| row_start | input | 1 | This pixel is the first of its row |
| ref_sig | input | SIG_W | Census signature from the reference image |
| tgt_sig | input | SIG_W | Census signature from the target image, same column |
| out_valid | output | 1 | Result present this cycle |
| out_disp | output | ceil(log2(NUM_DISP)) | Disparity of the best match |
| out_cost | output | ceil(log2(SIG_W+1)) | Hamming distance of the best match |

## Verification
The two functions most likely to meet in one cycle are the row-start exclusion and the minimum selection with its tie rule. Right after a row boundary, stale target history sits beside the few legal candidates and can equal or beat them. The bench provokes this by filling a row with one constant target signature and then starting a new row whose reference signatures are that same constant. An unmasked stale candidate would then score zero and win, so any result that points past column 0 is caught. Each result is judged against a bench model that keeps its own row history and picks the lowest count with the smallest disparity on ties.

// File: rtl/census_pkg.sv
package census_pkg;

   // Bits needed to hold a count from 0 to n inclusive
   function automatic int count_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   // Bits needed to index n items
   function automatic int index_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/cen_popcount.sv
module cen_popcount #(
   parameter int W  = 24,
   parameter int CW = 5
) (
   input  logic [W-1:0]  bits_i,
   output logic [CW-1:0] count_o
);

   // Loop bound is the vector width, so the adder chain fully unrolls
   always_comb begin
      count_o = '0;
      for (int b = 0; b < W; b++) begin
         count_o = count_o + CW'(bits_i[b]);
      end
   end

endmodule

// File: rtl/cen_cost_array.sv
module cen_cost_array #(
   parameter int SIG_W    = 24,
   parameter int NUM_DISP = 60,
   parameter int DIST_W   = 5,
   parameter int COL_W    = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   input  logic                             row_start,
   input  logic [SIG_W-1:0]                 ref_sig,
   input  logic [SIG_W-1:0]                 tgt_sig,
   output logic                             cost_valid,
   output logic [NUM_DISP-1:0][DIST_W-1:0]  cost
);

   localparam int              HIST_N  = NUM_DISP - 1;
   localparam logic [COL_W-1:0] COL_MAX = COL_W'(NUM_DISP - 1);

   logic [SIG_W-1:0] hist [HIST_N];
   logic [COL_W-1:0] col_cnt;
   logic [COL_W-1:0] cur_col;

   // Column of the pixel presented now, saturating at the window edge
   always_comb begin
      if (row_start)
         cur_col = '0;
      else if (col_cnt == COL_MAX)
         cur_col = COL_MAX;
      else
         cur_col = col_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_cnt    <= '0;
         cost_valid <= 1'b0;
      end else begin
         cost_valid <= in_valid;
         if (in_valid) col_cnt <= cur_col;
      end
   end

   // Row history: hist[k] holds the target signature k+1 columns back
   always_ff @(posedge clk) begin
      if (in_valid) begin
         hist[0] <= tgt_sig;
         for (int k = 1; k < HIST_N; k++) hist[k] <= hist[k-1];
      end
   end

   for (genvar d = 0; d < NUM_DISP; d++) begin : g_cand
      logic [SIG_W-1:0]  cand;
      logic [DIST_W-1:0] pc;
      logic [DIST_W-1:0] dq;

      if (d == 0) begin : g_now
         assign cand = tgt_sig;
      end else begin : g_old
         assign cand = hist[d-1];
      end

      cen_popcount #(.W(SIG_W), .CW(DIST_W)) u_pc (
         .bits_i  (ref_sig ^ cand),
         .count_o (pc)
      );

      always_ff @(posedge clk) begin
         if (in_valid) dq <= (d > int'(cur_col)) ? '1 : pc;
      end

      assign cost[d] = dq;
   end

endmodule

// File: rtl/cen_min_tree.sv
module cen_min_tree #(
   parameter int NUM_DISP = 60,
   parameter int DIST_W   = 5,
   parameter int IDX_W    = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   input  logic [NUM_DISP-1:0][DIST_W-1:0]  in_cost,
   output logic                             out_valid,
   output logic [IDX_W-1:0]                 out_idx,
   output logic [DIST_W-1:0]                out_cost
);

   localparam int LEVELS = $clog2(NUM_DISP);
   localparam int LEAVES = 1 << LEVELS;

   // Heap layout: node n has children 2n and 2n+1; leaves at LEAVES..2*LEAVES-1
   logic [DIST_W-1:0] node_d [1:2*LEAVES-1];
   logic [IDX_W-1:0]  node_i [1:2*LEAVES-1];
   logic [LEVELS-1:0] vpipe;

   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < NUM_DISP) begin : g_real
         assign node_d[LEAVES+i] = in_cost[i];
      end else begin : g_pad
         assign node_d[LEAVES+i] = '1;
      end
      assign node_i[LEAVES+i] = IDX_W'(i);
   end

   // One register per internal node; the left child holds lower disparities
   for (genvar n = 1; n < LEAVES; n++) begin : g_node
      logic [DIST_W-1:0] qd;
      logic [IDX_W-1:0]  qi;
      always_ff @(posedge clk) begin
         if (node_d[2*n] <= node_d[2*n+1]) begin
            qd <= node_d[2*n];
            qi <= node_i[2*n];
         end else begin
            qd <= node_d[2*n+1];
            qi <= node_i[2*n+1];
         end
      end
      assign node_d[n] = qd;
      assign node_i[n] = qi;
   end

   if (LEVELS == 1) begin : g_v1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vpipe <= '0;
         else        vpipe <= in_valid;
      end
   end else begin : g_vn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vpipe <= '0;
         else        vpipe <= {vpipe[LEVELS-2:0], in_valid};
      end
   end

   assign out_valid = vpipe[LEVELS-1];
   assign out_idx   = node_i[1];
   assign out_cost  = node_d[1];

endmodule

// File: rtl/cen_disparity_sel.sv
module cen_disparity_sel
   import census_pkg::*;
#(
   parameter int SIG_W    = 24,
   parameter int NUM_DISP = 60,
   localparam int DIST_W  = count_bits(SIG_W),
   localparam int IDX_W   = index_bits(NUM_DISP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              row_start,
   input  logic [SIG_W-1:0]  ref_sig,
   input  logic [SIG_W-1:0]  tgt_sig,
   output logic              out_valid,
   output logic [IDX_W-1:0]  out_disp,
   output logic [DIST_W-1:0] out_cost
);

   if (SIG_W < 1) begin : g_bad_sig
      $error("SIG_W must be at least 1");
   end
   if (NUM_DISP < 2) begin : g_bad_disp
      $error("NUM_DISP must be at least 2");
   end

   logic                            cost_valid;
   logic [NUM_DISP-1:0][DIST_W-1:0] cost;

   cen_cost_array #(
      .SIG_W    (SIG_W),
      .NUM_DISP (NUM_DISP),
      .DIST_W   (DIST_W),
      .COL_W    (IDX_W)
   ) u_cost (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .row_start  (row_start),
      .ref_sig    (ref_sig),
      .tgt_sig    (tgt_sig),
      .cost_valid (cost_valid),
      .cost       (cost)
   );

   cen_min_tree #(
      .NUM_DISP (NUM_DISP),
      .DIST_W   (DIST_W),
      .IDX_W    (IDX_W)
   ) u_tree (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (cost_valid),
      .in_cost   (cost),
      .out_valid (out_valid),
      .out_idx   (out_disp),
      .out_cost  (out_cost)
   );

endmodule

// File: rtl/cen_disparity_chk.sv
module cen_disparity_chk #(
   parameter int SIG_W    = 24,
   parameter int NUM_DISP = 60,
   parameter int DIST_W   = 5,
   parameter int IDX_W    = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              row_start,
   input logic              out_valid,
   input logic [IDX_W-1:0]  out_disp,
   input logic [DIST_W-1:0] out_cost
);

   localparam int              LAT     = 1 + $clog2(NUM_DISP);
   localparam logic [IDX_W-1:0] COL_MAX = IDX_W'(NUM_DISP - 1);

   logic [LAT-1:0]   vtrack;
   logic [IDX_W-1:0] ctrack [LAT];
   logic [IDX_W-1:0] ccnt;
   logic [IDX_W-1:0] cnow;

   assign cnow = row_start ? '0 : ((ccnt == COL_MAX) ? COL_MAX : ccnt + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vtrack <= '0;
         ccnt   <= '0;
         for (int k = 0; k < LAT; k++) ctrack[k] <= '0;
      end else begin
         vtrack    <= {vtrack[LAT-2:0], in_valid};
         ctrack[0] <= cnow;
         for (int k = 1; k < LAT; k++) ctrack[k] <= ctrack[k-1];
         if (in_valid) ccnt <= cnow;
      end
   end

   // R8
   latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vtrack[LAT-1]);

   // R2
   disp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_disp) < NUM_DISP));

   // R11
   cost_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_cost) <= SIG_W));

   // R5
   row_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_disp <= ctrack[LAT-1]));

   // R10
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);

endmodule

bind cen_disparity_sel cen_disparity_chk #(
   .SIG_W    (SIG_W),
   .NUM_DISP (NUM_DISP),
   .DIST_W   (DIST_W),
   .IDX_W    (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .row_start (row_start),
   .out_valid (out_valid),
   .out_disp  (out_disp),
   .out_cost  (out_cost)
);

// File: tb/sim_cen_disparity_sel.sv
`timescale 1ns/1ps
module sim_cen_disparity_sel;

   localparam int SW   = 24;
   localparam int ND   = 60;
   localparam int LAT  = 7;
   localparam int MAXC = 8192;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          row_start = 1'b0;
   logic [SW-1:0] ref_sig = '0;
   logic [SW-1:0] tgt_sig = '0;
   logic          out_valid;
   logic [5:0]    out_disp;
   logic [4:0]    out_cost;

   always #2.5 clk = ~clk;

   cen_disparity_sel #(.SIG_W(SW), .NUM_DISP(ND)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .row_start(row_start),
      .ref_sig(ref_sig), .tgt_sig(tgt_sig),
      .out_valid(out_valid), .out_disp(out_disp), .out_cost(out_cost)
   );

   int    checks = 0;
   int    fails  = 0;
   int    cyc    = 0;
   bit    done   = 1'b0;

   bit    ev [MAXC];
   int    ed [MAXC];
   int    ec [MAXC];
   string et [MAXC];

   logic [SW-1:0] tq [ND];
   int            col = 0;
   logic [SW-1:0] rowbuf [512];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // One clock: judge outputs, then drive and model the next pixel
   task automatic step(input bit v, input bit rs, input logic [SW-1:0] r,
                       input logic [SW-1:0] t, input string tag);
      bit expv;
      @(negedge clk);
      expv = (cyc >= LAT) ? ev[cyc-LAT] : 1'b0;
      chk(out_valid == expv, "R8", int'(out_valid), int'(expv));
      if (expv) begin
         chk(int'(out_disp) == ed[cyc-LAT], et[cyc-LAT], int'(out_disp), ed[cyc-LAT]);
         chk(int'(out_cost) == ec[cyc-LAT], "R11", int'(out_cost), ec[cyc-LAT]);
      end
      in_valid  = v;
      row_start = rs;
      ref_sig   = r;
      tgt_sig   = t;
      ev[cyc] = v;
      et[cyc] = tag;
      if (v) begin
         int best_d;
         int best_c;
         col = rs ? 0 : col + 1;
         for (int k = ND - 1; k > 0; k--) tq[k] = tq[k-1];
         tq[0] = t;
         best_d = 0;
         best_c = 1000;
         for (int d = 0; d < ND; d++) begin
            if (d <= col) begin
               int c;
               c = $countones(r ^ tq[d]);
               if (c < best_c) begin
                  best_c = c;
                  best_d = d;
               end
            end
         end
         ed[cyc] = best_d;
         ec[cyc] = best_c;
      end
      cyc++;
   endtask

   // mode 0: random; 1: reference copies target shifted by shft;
   // 2: both sides constant kval; 3: reference constant kval, target random
   task automatic run_row(input int len, input int vprob, input int mode,
                          input int shft, input logic [SW-1:0] kval, input string tag);
      for (int u = 0; u < len; u++) begin
         logic [SW-1:0] t;
         logic [SW-1:0] r;
         while (($urandom % 100) >= vprob)
            step(1'b0, 1'b0, SW'($urandom), SW'($urandom), tag);
         t = SW'($urandom);
         r = SW'($urandom);
         case (mode)
            1: if (u >= shft) r = rowbuf[u-shft];
            2: begin t = kval; r = kval; end
            3: r = kval;
            default: ;
         endcase
         rowbuf[u] = t;
         step(1'b1, u == 0, r, t, tag);
      end
   endtask

   initial begin
      void'($urandom(32'd20251));
      for (int k = 0; k < ND; k++) tq[k] = '0;
      repeat (3) begin
         @(negedge clk);
         // R10: nothing leaves the block while reset is held
         chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
      end
      rst_n = 1'b1;
      for (int n = 0; n < 3; n++) run_row(100, 80, 0, 0, '0, "R1");
      run_row(120, 100, 1, 59, '0, "R2");
      run_row(80, 70, 1, 17, '0, "R3");
      run_row(70, 90, 2, 0, 24'h5A3C96, "R4");
      run_row(70, 90, 3, 0, 24'h5A3C96, "R5");
      for (int n = 0; n < 30; n++) run_row(1 + ($urandom % 8), 85, 0, 0, '0, "R6");
      run_row(70, 100, 2, 0, 24'h0F0F0F, "R4");
      run_row(40, 100, 3, 0, 24'h0F0F0F, "R5");
      for (int n = 0; n < 2; n++) run_row(200, 100, 0, 0, '0, "R7");
      run_row(60, 30, 1, 9, '0, "R9");
      run_row(60, 30, 0, 0, '0, "R9");
      repeat (LAT + 3) step(1'b0, 1'b0, '0, '0, "R8");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule